// File: doc/BRIEF.md
# Latched Performance Error Counter Bank

This block keeps a set of error counters for performance monitoring, one per error source (parity faults, remote-error reports and the like). Each counter has a running accumulator that advances whenever its source reports errors, and a hold register that a processor reads. The processor reads the hold registers, never the running accumulators, so the value it sees does not move while it reads.

A snapshot is taken when the processor's control bit goes from 0 to 1. In that one cycle every running value is copied into its hold register, and every running accumulator starts a new interval. All counters are captured on the same cycle, so the held values describe one common interval. Each source offers an increment value per cycle; zero means no error in that cycle. Running accumulators saturate at their top value rather than wrapping.

Top module: `perf_snap_bank`

## Requirements
- R1: After a cycle with `rst_n` low, every hold register and every running accumulator is zero, so every readable address returns 0.
- R2: In a cycle with no snapshot, running accumulator i grows by the value on its slice of `err_inc_i`, bits [i*INC_W +: INC_W], where 0 means no error.
- R3: A snapshot happens only in a cycle where `snap_ctl_i` is 1 and was 0 in the previous cycle. Keeping the bit at 1 for more cycles takes no further snapshot.
- R4: A snapshot copies every running accumulator into its own hold register in the same cycle.
- R5: A snapshot restarts every running accumulator. An increment that arrives in the snapshot cycle is counted in the new interval, so the next snapshot includes it.
- R6: A hold register does not change between snapshots, whatever errors arrive.
- R7: A running accumulator stops at 2^CNT_W-1 and does not wrap. An increment that would pass this value leaves the accumulator at 2^CNT_W-1.
- R8: `rd_data_o` shows the hold register of counter `rd_addr_i` without a clock delay. For addresses N_CNT and above it shows 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_inc_i | input | N_CNT*INC_W | Increment value for each counter in this cycle, counter i in bits [i*INC_W +: INC_W] |
| snap_ctl_i | input | 1 | Processor snapshot control bit; a 0 to 1 change takes a snapshot |
| rd_addr_i | input | ADDR_W | Index of the hold register to read |
| rd_data_o | output | CNT_W | Contents of the selected hold register, or 0 for an unused address |

## Verification
The assertions check these rules on every cycle: a hold register changes only on a snapshot; a snapshot takes the previous running value and restarts the accumulator at the increment of that cycle; an accumulator never moves backwards between snapshots and stays at its top value once there; two snapshots never occur on consecutive cycles; unused addresses read 0. Other properties depend on a history of input activity and need the bench scenarios. These are that each held count equals the number of errors injected over the interval, that errors arriving while the control bit stays high are counted in the next snapshot, and that an error arriving in the snapshot cycle moves to the next interval.

// File: rtl/perf_cnt_pkg.sv
// Package: default sizing shared by the counter bank and its parts.
// Assumes: INC_W is not wider than CNT_W wherever these defaults are overridden.
package perf_cnt_pkg;
    localparam int DEF_N_CNT = 4;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_INC_W = 4;
endpackage

// File: rtl/snap_edge_det.sv
// Module: snap_edge_det
// Turns the processor control bit into a one-cycle snapshot pulse when the bit
// changes from 0 to 1. Assumes the bit is already synchronous to clk.
// After reset the previous value is taken as 0.
module snap_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_i,
    output logic snap_o
);
    logic ctl_q;

    // Store the control bit from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= 1'b0;
        else        ctl_q <= ctl_i;
    end

    // Pulse only on a 0 to 1 change.
    always_comb snap_o = ctl_i & ~ctl_q;

    AST_NO_BACK_TO_BACK_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        snap_o |=> !snap_o); // R3
endmodule

// File: rtl/perf_cnt_slice.sv
// Module: perf_cnt_slice
// One counter: a saturating running accumulator and a hold register.
// On snap_i the hold register takes the running value, and the accumulator
// restarts at the increment of this cycle so that no error is lost.
// Assumes INC_W <= CNT_W.
module perf_cnt_slice #(
    parameter int CNT_W = perf_cnt_pkg::DEF_CNT_W,
    parameter int INC_W = perf_cnt_pkg::DEF_INC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] hold_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] run_nxt;

    // Add the increment to the running value, or to zero on a snapshot, and saturate.
    always_comb begin
        base    = snap_i ? '0 : run_q;
        sum     = {1'b0, base} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};
        run_nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    // Running accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_nxt;
    end

    // Hold register: loads only on a snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_o <= '0;
        else if (snap_i) hold_o <= run_q;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (run_q == '0) && (hold_o == '0)); // R1
    AST_RUN_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> run_q >= $past(run_q)); // R2
    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> hold_o == $past(run_q)); // R4
    AST_RESTART_WITH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> run_q == {{(CNT_W - INC_W){1'b0}}, $past(inc_i)}); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(hold_o)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_i && run_q == CNT_MAX) |=> run_q == CNT_MAX); // R7
endmodule

// File: rtl/hold_rd_mux.sv
// Module: hold_rd_mux
// Selects one hold register for the processor read port with no clock delay.
// Addresses beyond the bank return zero.
module hold_rd_mux #(
    parameter int N_CNT  = perf_cnt_pkg::DEF_N_CNT,
    parameter int CNT_W  = perf_cnt_pkg::DEF_CNT_W,
    parameter int ADDR_W = $clog2(N_CNT) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CNT*CNT_W-1:0] hold_i,
    input  logic [ADDR_W-1:0]      addr_i,
    output logic [CNT_W-1:0]       data_o
);
    // Compare the address with each index; the default result is zero.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (addr_i == ADDR_W'(i)) data_o = hold_i[i*CNT_W +: CNT_W];
        end
    end

    AST_UNUSED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) >= N_CNT) |-> data_o == '0); // R8
endmodule

// File: rtl/perf_snap_bank.sv
// Module: perf_snap_bank (top)
// Bank of N_CNT latched error counters. A 0 to 1 change on snap_ctl_i copies
// every running value into its hold register on the same cycle and restarts
// all accumulators. Assumes every input is synchronous to clk.
module perf_snap_bank #(
    parameter int N_CNT  = perf_cnt_pkg::DEF_N_CNT,
    parameter int CNT_W  = perf_cnt_pkg::DEF_CNT_W,
    parameter int INC_W  = perf_cnt_pkg::DEF_INC_W,
    parameter int ADDR_W = $clog2(N_CNT) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CNT*INC_W-1:0] err_inc_i,
    input  logic                   snap_ctl_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [CNT_W-1:0]       rd_data_o
);
    logic                   snap;
    logic [N_CNT*CNT_W-1:0] hold_flat;

    snap_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (snap_ctl_i),
        .snap_o (snap)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_slice
        perf_cnt_slice #(.CNT_W(CNT_W), .INC_W(INC_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .snap_i (snap),
            .inc_i  (err_inc_i[g*INC_W +: INC_W]),
            .hold_o (hold_flat[g*CNT_W +: CNT_W])
        );
    end

    hold_rd_mux #(.N_CNT(N_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_flat),
        .addr_i (rd_addr_i),
        .data_o (rd_data_o)
    );

    AST_SNAP_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        snap |-> $rose(snap_ctl_i)); // R3
endmodule

// File: tb/tb_perf_snap_bank.sv
// Scoreboard bench: the driver keeps a model of the counts and pushes the
// expected reads into a queue; the monitor pops, reads the port and compares.
module tb_perf_snap_bank;
    localparam int N      = 4;
    localparam int CW     = 8;
    localparam int IW     = 4;
    localparam int AW     = $clog2(N) + 1;
    localparam int MAXV   = (1 << CW) - 1;

    typedef struct {
        int    addr;
        int    exp;
        string req;
    } sb_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*IW-1:0] err_inc = '0;
    logic            snap_ctl = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [CW-1:0]   rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit busy   = 1'b0;
    sb_item_t sbq[$];
    int model_run[N];
    int model_hold[N];

    perf_snap_bank #(.N_CNT(N), .CNT_W(CW), .INC_W(IW), .ADDR_W(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_inc_i  (err_inc),
        .snap_ctl_i (snap_ctl),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Monitor: pop an expected item, read that address, compare.
    initial begin
        forever begin
            wait (sbq.size() > 0);
            busy = 1'b1;
            begin
                sb_item_t it;
                it = sbq.pop_front();
                rd_addr = AW'(it.addr);
                #1;
                checks++;
                if (int'(rd_data) != it.exp) begin
                    fails++;
                    $display("FAIL %s addr %0d: actual %0d expected %0d",
                             it.req, it.addr, rd_data, it.exp);
                end
            end
            busy = 1'b0;
        end
    end

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic push_item(input int a, input int e, input string r);
        sb_item_t it;
        it.addr = a;
        it.exp  = e;
        it.req  = r;
        sbq.push_back(it);
    endtask

    // Push the expected held value of every counter, then wait for the monitor.
    task automatic expect_all(input string r);
        for (int i = 0; i < N; i++) push_item(i, model_hold[i], r);
        wait (sbq.size() == 0 && !busy);
    endtask

    // Drive one cycle of increments and control level; update the model.
    task automatic drive_cycle(input int inc[N], input bit ctl);
        bit prev;
        bit snap;
        prev = snap_ctl;
        snap = ctl && !prev;
        @(negedge clk);
        snap_ctl = ctl;
        for (int i = 0; i < N; i++) err_inc[i*IW +: IW] = IW'(inc[i]);
        for (int i = 0; i < N; i++) begin
            if (snap) begin
                model_hold[i] = model_run[i];
                model_run[i]  = inc[i];
            end else begin
                model_run[i]  = sat(model_run[i] + inc[i]);
            end
        end
    endtask

    task automatic random_cycles(input int n, input bit ctl);
        int inc[N];
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < N; i++)
                inc[i] = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 15)) : 0;
            drive_cycle(inc, ctl);
        end
    endtask

    task automatic idle(input int n, input bit ctl);
        int z[N];
        for (int i = 0; i < N; i++) z[i] = 0;
        for (int k = 0; k < n; k++) drive_cycle(z, ctl);
    endtask

    // Settle one edge so the last driven cycle is applied, then read.
    task automatic settle;
        @(negedge clk);
        err_inc = '0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            model_run[i] = 0;
            model_hold[i] = 0;
        end
        err_inc = '1;
        repeat (3) @(negedge clk);
        err_inc = '0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_all("R1");
        for (int a = N; a < (1 << AW); a++) push_item(a, 0, "R1");
        wait (sbq.size() == 0 && !busy);

        // R2 R4: random errors over an interval, then one snapshot
        random_cycles(40, 1'b0);
        random_cycles(1, 1'b1);
        settle();
        expect_all("R2_R4");

        // R6: errors without a snapshot leave held values untouched
        idle(1, 1'b0);
        random_cycles(30, 1'b0);
        settle();
        expect_all("R6");

        // R3: control kept high with errors arriving takes no snapshot
        random_cycles(1, 1'b1);
        random_cycles(20, 1'b1);
        settle();
        expect_all("R3_level");
        // R3: a new 0 to 1 change counts the errors seen while high
        idle(1, 1'b0);
        random_cycles(1, 1'b1);
        settle();
        expect_all("R3_edge");

        // R5: error in the snapshot cycle belongs to the next interval
        begin
            int inc[N];
            idle(1, 1'b0);
            for (int i = 0; i < N; i++) inc[i] = i + 5;
            drive_cycle(inc, 1'b1);
            idle(2, 1'b0);
            idle(1, 1'b1);
            settle();
            expect_all("R5");
        end

        // R7: counter 0 driven past its top value saturates
        begin
            int inc[N];
            idle(1, 1'b0);
            inc[0] = 15; inc[1] = 1; inc[2] = 0; inc[3] = 15;
            for (int k = 0; k < 30; k++) drive_cycle(inc, 1'b0);
            idle(1, 1'b1);
            settle();
            expect_all("R7");
            checks++;
            if (model_hold[0] != MAXV) begin
                fails++;
                $display("FAIL R7 model: actual %0d expected %0d", model_hold[0], MAXV);
            end
        end

        // R8: every address, including unused ones
        for (int a = 0; a < (1 << AW); a++)
            push_item(a, (a < N) ? model_hold[a] : 0, "R8");
        wait (sbq.size() == 0 && !busy);

        // R1: reset mid-run clears everything
        random_cycles(10, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        snap_ctl = 1'b0;
        err_inc = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            model_run[i] = 0;
            model_hold[i] = 0;
        end
        expect_all("R1_mid");
        idle(1, 1'b1);
        settle();
        expect_all("R1_run_zero");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule